// File: doc/BRIEF.md
# Timer Tick Source Selector and Prescaler

This block produces the count-enable pulse that drives a small modulo timer. A byte-wide configuration register picks the source of counting events and a power-of-two divide ratio. The bus clock itself, a fixed-frequency strobe, or either edge of an external pin can serve as the source. The external pin is brought into the bus-clock domain through a synchroniser before its edges are detected.

Each source event advances an 8-bit prescaler. A registered one-cycle tick is issued when the low bits of the prescaler, as many as the divide code names, are all ones. The configuration can be rewritten while the timer runs. The prescaler keeps its value across such a write, so counting simply continues under the new setting. A global enable freezes the prescaler and suppresses ticks.

Top module: `tick_prescaler`

## Requirements
- R1: After reset the configuration reads 0x00 (bus clock, divide by 1), tick is low, and the prescaler is zero, so the first enabled bus-clock event already ticks.
- R2: cfg_rdata returns bits 5:0 as last written and always returns 0 in bits 7:6. Bits 5:4 hold the source select and bits 3:0 hold the divide code.
- R3: Source select 00 treats every bus-clock cycle as an event.
- R4: Source select 01 counts one event per cycle in which fix_stb is high.
- R5: Source select 10 counts falling edges of ext_pin. A pin change made between edges shows up as a tick three rising clock edges later. Rising edges produce no event.
- R6: Source select 11 counts rising edges of ext_pin with the same latency. Falling edges produce no event.
- R7: Divide code c in 0..8 yields exactly one tick per 2^c events. Starting from prescaler zero, the tick comes on event 2^c.
- R8: Divide codes 9..15 behave exactly like code 8, giving one tick per 256 events.
- R9: A configuration write never clears the prescaler. The event in the write cycle uses the old setting, and later events use the new one.
- R10: While enable is low the prescaler holds its value and tick stays low.
- R11: tick is registered. It is high only in the cycle following an event edge that matched, so with divide by 2 it alternates 0,1,0,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global count enable |
| fix_stb | input | 1 | Fixed-frequency strobe, one bus cycle wide |
| ext_pin | input | 1 | Asynchronous external clock pin |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| tick | output | 1 | One-cycle count-enable pulse |

## Verification
A configuration write can land on the same clock edge as a source event that moves the prescaler. The bench provokes this while the timer runs on the bus clock. It holds divide by 8 for two events, then writes divide by 4 in the third enabled cycle. It expects no tick from the write cycle, because the old mask applies and the prescaler moves from 2 to 3. It expects a tick on the very next event, because the new mask sees 3 and the prescaler was not cleared. A second write, which switches to the strobe source in a running cycle, is judged by the strobe count that is needed to reach the next tick.

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W  = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fix_stb,
  input  logic              ext_pin,
  input  logic              cfg_we,
  input  logic [CODE_W+3:0] cfg_wdata,
  output logic [CODE_W+3:0] cfg_rdata,
  output logic              tick
);
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(PRE_W);
  localparam logic [PRE_W-1:0]  ONE      = PRE_W'(1);

  logic [1:0]        src_sel;
  logic [CODE_W-1:0] div_code;
  logic [2:0]        pin_sync;
  logic [PRE_W-1:0]  pre;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      src_sel  <= '0;
      div_code <= '0;
    end else if (cfg_we) begin
      src_sel  <= cfg_wdata[CODE_W+1:CODE_W];
      div_code <= cfg_wdata[CODE_W-1:0];
    end

  assign cfg_rdata = {2'b00, src_sel, div_code};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[1:0], ext_pin};

  wire pin_fall = pin_sync[2] & ~pin_sync[1];
  wire pin_rise = ~pin_sync[2] & pin_sync[1];

  logic src_evt;
  always_comb
    case (src_sel)
      2'b00:   src_evt = 1'b1;
      2'b01:   src_evt = fix_stb;
      2'b10:   src_evt = pin_fall;
      default: src_evt = pin_rise;
    endcase

  wire [CODE_W-1:0] eff_code = (div_code > MAX_CODE) ? MAX_CODE : div_code;
  wire [PRE_W-1:0]  low_mask = (ONE << eff_code) - ONE;
  wire              advance  = enable & src_evt;
  wire              hit      = advance & ((pre & low_mask) == low_mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre  <= '0;
      tick <= 1'b0;
    end else begin
      if (advance) pre <= pre + ONE;
      tick <= hit;
    end

  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CODE_W+3:CODE_W+2] == 2'b00);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[CODE_W+1:0] == $past(cfg_wdata[CODE_W+1:0]));

  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(rst_n)) |=> (pre == $past(pre)) && !tick);

  a_r9_advance_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(advance)) |-> pre == $past(pre) + ONE);

  a_r11_tick_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && tick) |-> ($past(enable) && $past(src_evt)));
endmodule

// File: tb/tb_tick_prescaler.sv
module tb_tick_prescaler;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, fix_stb = 1'b0, ext_pin = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic tick;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_prescaler dut (.clk, .rst_n, .enable, .fix_stb, .ext_pin,
                      .cfg_we, .cfg_wdata, .cfg_rdata, .tick);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin step(); cnt += int'(tick); end
  endtask

  task automatic do_reset();
    enable = 0; cfg_we = 0; fix_stb = 0; ext_pin = 0;
    @(negedge clk); rst_n = 0; step(); rst_n = 1; step();
  endtask

  task automatic write_cfg(logic [7:0] v);
    cfg_wdata = v; cfg_we = 1; step(); cfg_we = 0;
  endtask

  task automatic t_reset();
    int c;
    do_reset();
    check("R1 rdata", cfg_rdata, 0);
    check("R1 tick", tick, 0);
    enable = 1; run(1, c); enable = 0;
    check("R1/R3 first event ticks", c, 1);
  endtask

  task automatic t_readback();
    do_reset();
    write_cfg(8'hFF); check("R2 ff", cfg_rdata, 8'h3F);
    write_cfg(8'hC5); check("R2 c5", cfg_rdata, 8'h05);
  endtask

  task automatic t_divide(int code);
    int c, k;
    k = 1 << ((code > 8) ? 8 : code);
    do_reset(); write_cfg(8'(code)); enable = 1;
    run(k - 1, c); check(code > 8 ? "R8 before" : "R7 before", c, 0);
    run(1, c);     check(code > 8 ? "R8 on" : "R7 on", c, 1);
    run(k, c);     check(code > 8 ? "R8 period" : "R7 period", c, 1);
    enable = 0;
  endtask

  task automatic t_fixed();
    int c, tot;
    do_reset(); write_cfg(8'h11); enable = 1;
    run(10, c); check("R4 idle", c, 0);
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      fix_stb = 1; run(1, c); tot += c; fix_stb = 0; run(1, c); tot += c;
    end
    check("R4 four strobes div2", tot, 2);
    enable = 0;
  endtask

  task automatic t_ext();
    int c;
    do_reset(); write_cfg(8'h20); enable = 1;
    ext_pin = 1; run(2, c); check("R5 rise ignored", c, 0);
    run(2, c); check("R5 rise ignored late", c, 0);
    ext_pin = 0; run(2, c); check("R5 not before 3 edges", c, 0);
    run(1, c); check("R5 fall at 3rd edge", c, 1);
    run(2, c); check("R5 single", c, 0);
    write_cfg(8'h30);
    ext_pin = 1; run(4, c); check("R6 rise", c, 1);
    ext_pin = 0; run(4, c); check("R6 fall ignored", c, 0);
    enable = 0;
  endtask

  task automatic t_enable();
    int c;
    do_reset(); write_cfg(8'h02); enable = 1;
    run(2, c); check("R10 pre", c, 0);
    enable = 0; run(10, c); check("R10 off no tick", c, 0);
    enable = 1; run(1, c); check("R10 held 3rd", c, 0);
    run(1, c); check("R10 held 4th", c, 1);
    enable = 0;
  endtask

  task automatic t_live();
    int c;
    do_reset(); write_cfg(8'h03); enable = 1;
    run(2, c); check("R9 two events", c, 0);
    cfg_wdata = 8'h02; cfg_we = 1; step(); cfg_we = 0;
    check("R9 write cycle old mask", tick, 0);
    run(1, c); check("R9 kept count", c, 1);
    cfg_wdata = 8'h13; cfg_we = 1; step(); cfg_we = 0;
    check("R9 switch cycle", tick, 0);
    run(3, c); check("R9 no strobe", c, 0);
    fix_stb = 1; run(1, c); fix_stb = 0; run(1, c);
    fix_stb = 1; run(1, c); fix_stb = 0; run(1, c);
    check("R9 two strobes", c, 0);
    fix_stb = 1; run(1, c); fix_stb = 0;
    check("R9 third strobe", c, 1);
    enable = 0;
  endtask

  task automatic t_width();
    do_reset(); write_cfg(8'h01); enable = 1;
    for (int i = 0; i < 6; i++) begin
      step(); check("R11 alternate", tick, i % 2);
    end
    enable = 0;
  endtask

  initial begin
    t_reset();
    t_readback();
    for (int code = 0; code <= 8; code++) t_divide(code);
    t_divide(9);
    t_divide(15);
    t_fixed();
    t_ext();
    t_enable();
    t_live();
    t_width();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule